// File: doc/BRIEF.md
# Spectrum bar visualizer

This block turns the low end of a finished spectrum into a live bar display. When the transform engine signals that a new result is ready, a loader reads the lowest 32 magnitude bins from the result memory through a synchronous read port. It adds the bins in adjacent pairs, scales each sum by a right shift, clamps it to the screen height, and stores 16 bar heights. A raster engine in the pixel clock domain produces standard 640x480 timing with active-low sync pulses. It paints the 16 bars side by side across the visible width, with each bar growing upward from the bottom line.

The loader runs on the fast system clock and the raster runs on the pixel clock. The raster reports a registered "safe to update" flag that is high during vertical blanking, except for the last blanking line. The loader brings this flag into its own domain through two flops and only issues memory reads while the flag is high. As a result, the stored heights never change while a visible pixel is being produced. Three active-low switches remove the red, green and blue channels. With all switches released, the bars are white on a black background.

Top module: `spectrum_bars`

## Requirements
- R1: Only bins 0 to NUM_BARS*BINS_PER_BAR-1 (0 to 31 by default) are read from the spectrum memory. The contents of every higher bin have no effect on the picture.
- R2: The height of bar i is min((bin[2i] + bin[2i+1]) >> SHIFT, V_ACTIVE), where the sum is taken without overflow.
- R3: A visible pixel at column h and line v is lit exactly when v >= V_ACTIVE - height[h / (H_ACTIVE/NUM_BARS)]. A bar of height 0 therefore draws nothing.
- R4: The loader stays idle until xform_done is high for a clock. If the spectrum memory changes without a done pulse, the displayed bars do not change.
- R5: The bar heights change only during vertical blanking. A frame that is already being drawn keeps its old bars until that frame ends.
- R6: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP pixel clocks. vga_hs_n is low for columns H_ACTIVE+H_FP to H_ACTIVE+H_FP+H_SYNC-1. Every output shows the raster position one pixel clock after it is reached.
- R7: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. vga_vs_n is low for lines V_ACTIVE+V_FP to V_ACTIVE+V_FP+V_SYNC-1 and changes only at the start of a line.
- R8: Outside the visible area (h >= H_ACTIVE or v >= V_ACTIVE), all colour outputs are zero.
- R9: sw_n[0], sw_n[1] and sw_n[2] gate red, green and blue. A lit channel is all ones when its switch bit is 1 and zero when the bit is 0.
- R10: During reset, both syncs are high, all colours are zero and every bar height is zero. The first frame after reset is therefore entirely dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| load_clk | input | 1 | Fast clock for the loader and the memory read port |
| pix_clk | input | 1 | Pixel clock for the raster |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| xform_done | input | 1 | Transform finished, one load_clk pulse (load_clk domain) |
| spec_rd_en | output | 1 | Read strobe to the spectrum memory |
| spec_rd_addr | output | ADDR_W (8) | Bin address to read |
| spec_rd_data | input | MAG_W (16) | Bin magnitude, valid one load_clk after the strobe |
| sw_n | input | 3 | Active-low channel switches: bit 0 red, bit 1 green, bit 2 blue |
| vga_hs_n | output | 1 | Horizontal sync, active low |
| vga_vs_n | output | 1 | Vertical sync, active low |
| vga_r | output | COLOR_W (4) | Red channel |
| vga_g | output | COLOR_W (4) | Green channel |
| vga_b | output | COLOR_W (4) | Blue channel |

## Verification
The bench builds the block with a reduced raster: 64 visible columns (4 per bar) with 2/4/2 horizontal porch and sync, and 32 visible lines with 1/2/1 vertical porch and sync. SHIFT is 4, while the magnitude width stays at 16 bits. Each frame then lasts 2592 pixel clocks, so a dozen frames can be compared pixel by pixel: every sync edge and every bar edge, a bar at zero, a bar at exactly full height, and sums far above the clamp. The run also covers a memory change with no done pulse, a load requested in the middle of a frame, and every switch combination that matters.

// File: rtl/spectrum_bars_pkg.sv
package spectrum_bars_pkg;

   typedef enum logic {
      LD_HOLD = 1'b0,
      LD_READ = 1'b1
   } sb_load_e;

   localparam int SB_CHANNELS = 3;

endpackage

// File: rtl/sb_loader.sv
module sb_loader
   import spectrum_bars_pkg::*;
#(
   parameter int MAG_W        = 16,
   parameter int ADDR_W       = 8,
   parameter int NUM_BARS     = 16,
   parameter int BINS_PER_BAR = 2,
   parameter int SHIFT        = 7,
   parameter int V_ACTIVE     = 480,
   parameter int HGT_W        = 9
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             xform_done,
   input  logic                             upd_ok_pix,
   output logic                             rd_en,
   output logic [ADDR_W-1:0]                rd_addr,
   input  logic [MAG_W-1:0]                 rd_data,
   output logic [NUM_BARS-1:0][HGT_W-1:0]   heights_o
);

   localparam int NBINS = NUM_BARS * BINS_PER_BAR;
   localparam int CNT_W = $clog2(NBINS);
   localparam int GRP_W = $clog2(BINS_PER_BAR);
   localparam int BAR_W = CNT_W - GRP_W;
   localparam int SUM_W = MAG_W + GRP_W;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBINS - 1);

   sb_load_e            state;
   logic [1:0]          ok_sync;
   logic                ok_s;
   logic [CNT_W-1:0]    cnt;
   logic                rd_vld;
   logic [CNT_W-1:0]    rd_idx;
   logic [SUM_W-1:0]    acc;
   logic [SUM_W-1:0]    sum_now;
   logic [SUM_W-1:0]    scaled;
   logic [HGT_W-1:0]    wr_height;
   logic                bar_we;
   logic [BAR_W-1:0]    bar_sel;

   assign ok_s = ok_sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ok_sync <= '0;
      else        ok_sync <= {ok_sync[0], upd_ok_pix};
   end

   // Two-state walker: idle until done, then sweep the low bins while allowed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LD_HOLD;
         cnt   <= '0;
      end else begin
         case (state)
            LD_HOLD: if (xform_done) begin
               state <= LD_READ;
               cnt   <= '0;
            end
            LD_READ: if (ok_s) begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_LAST) state <= LD_HOLD;
            end
            default: state <= LD_HOLD;
         endcase
      end
   end

   always_comb begin
      rd_en   = (state == LD_READ) && ok_s;
      rd_addr = ADDR_W'(cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld <= 1'b0;
         rd_idx <= '0;
      end else begin
         rd_vld <= rd_en;
         rd_idx <= cnt;
      end
   end

   always_comb begin
      sum_now   = ((rd_idx[GRP_W-1:0] == '0) ? '0 : acc) + SUM_W'(rd_data);
      scaled    = sum_now >> SHIFT;
      wr_height = (scaled > SUM_W'(V_ACTIVE)) ? HGT_W'(V_ACTIVE) : HGT_W'(scaled);
      bar_we    = rd_vld && (rd_idx[GRP_W-1:0] == '1);
      bar_sel   = rd_idx[CNT_W-1:GRP_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         heights_o <= '0;
      end else if (rd_vld) begin
         acc <= sum_now;
         if (bar_we) heights_o[bar_sel] <= wr_height;
      end
   end

   assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr < ADDR_W'(NBINS)));

   assert_hold_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LD_HOLD && !xform_done) |=> (state == LD_HOLD));

endmodule

// File: rtl/sb_timing.sv
module sb_timing #(
   parameter int H_ACTIVE = 640,
   parameter int H_FP     = 16,
   parameter int H_SYNC   = 96,
   parameter int H_BP     = 48,
   parameter int V_ACTIVE = 480,
   parameter int V_FP     = 10,
   parameter int V_SYNC   = 2,
   parameter int V_BP     = 33,
   parameter int H_W      = 10,
   parameter int V_W      = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [H_W-1:0] h_o,
   output logic [V_W-1:0] v_o,
   output logic           active_o,
   output logic           hs_n_o,
   output logic           vs_n_o,
   output logic           upd_ok_o
);

   localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
   localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
   localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
   localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);
   localparam logic [H_W-1:0] H_VIS  = H_W'(H_ACTIVE);
   localparam logic [V_W-1:0] V_VIS  = V_W'(V_ACTIVE);
   localparam logic [H_W-1:0] HS_BEG = H_W'(H_ACTIVE + H_FP);
   localparam logic [H_W-1:0] HS_END = H_W'(H_ACTIVE + H_FP + H_SYNC);
   localparam logic [V_W-1:0] VS_BEG = V_W'(V_ACTIVE + V_FP);
   localparam logic [V_W-1:0] VS_END = V_W'(V_ACTIVE + V_FP + V_SYNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_o      <= '0;
         v_o      <= '0;
         upd_ok_o <= 1'b0;
      end else begin
         if (h_o == H_LAST) begin
            h_o <= '0;
            v_o <= (v_o == V_LAST) ? '0 : v_o + 1'b1;
         end else begin
            h_o <= h_o + 1'b1;
         end
         // Blanking minus its last line leaves a line of margin for the crossing.
         upd_ok_o <= (v_o >= V_VIS) && (v_o < V_LAST);
      end
   end

   always_comb begin
      active_o = (h_o < H_VIS) && (v_o < V_VIS);
      hs_n_o   = !((h_o >= HS_BEG) && (h_o < HS_END));
      vs_n_o   = !((v_o >= VS_BEG) && (v_o < VS_END));
   end

   assert_hwrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (h_o == H_LAST) |=> (h_o == '0));

   assert_vs_line_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_n_o != $past(vs_n_o)) |-> (h_o == '0));

endmodule

// File: rtl/sb_raster.sv
module sb_raster
   import spectrum_bars_pkg::*;
#(
   parameter int H_ACTIVE = 640,
   parameter int V_ACTIVE = 480,
   parameter int NUM_BARS = 16,
   parameter int HGT_W    = 9,
   parameter int COLOR_W  = 4,
   parameter int H_W      = 10,
   parameter int V_W      = 10
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [H_W-1:0]                         h_i,
   input  logic [V_W-1:0]                         v_i,
   input  logic                                   active_i,
   input  logic                                   hs_n_i,
   input  logic                                   vs_n_i,
   input  logic [NUM_BARS-1:0][HGT_W-1:0]         heights_i,
   input  logic [SB_CHANNELS-1:0]                 sw_n,
   output logic                                   hs_n_o,
   output logic                                   vs_n_o,
   output logic [SB_CHANNELS-1:0][COLOR_W-1:0]    rgb_o
);

   localparam int BAR_PIX = H_ACTIVE / NUM_BARS;
   localparam int BAR_W   = $clog2(NUM_BARS);

   logic [BAR_W-1:0]       bar_sel;
   logic [HGT_W-1:0]       hgt;
   logic                   lit;
   logic [SB_CHANNELS-1:0] chan_on;

   always_comb begin
      bar_sel = BAR_W'(h_i / H_W'(BAR_PIX));
      hgt     = heights_i[bar_sel];
      lit     = active_i && (v_i >= (V_W'(V_ACTIVE) - V_W'(hgt)));
      chan_on = {SB_CHANNELS{lit}} & sw_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_n_o <= 1'b1;
         vs_n_o <= 1'b1;
      end else begin
         hs_n_o <= hs_n_i;
         vs_n_o <= vs_n_i;
      end
   end

   for (genvar c = 0; c < SB_CHANNELS; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rgb_o[c] <= '0;
         else        rgb_o[c] <= chan_on[c] ? '1 : '0;
      end
   end

   assert_heights_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && $past(active_i)) |-> $stable(heights_i));

endmodule

// File: rtl/spectrum_bars.sv
module spectrum_bars
   import spectrum_bars_pkg::*;
#(
   parameter int MAG_W        = 16,
   parameter int ADDR_W       = 8,
   parameter int NUM_BARS     = 16,
   parameter int BINS_PER_BAR = 2,
   parameter int SHIFT        = 7,
   parameter int COLOR_W      = 4,
   parameter int H_ACTIVE     = 640,
   parameter int H_FP         = 16,
   parameter int H_SYNC       = 96,
   parameter int H_BP         = 48,
   parameter int V_ACTIVE     = 480,
   parameter int V_FP         = 10,
   parameter int V_SYNC       = 2,
   parameter int V_BP         = 33
) (
   input  logic               load_clk,
   input  logic               pix_clk,
   input  logic               rst_n,
   input  logic               xform_done,
   output logic               spec_rd_en,
   output logic [ADDR_W-1:0]  spec_rd_addr,
   input  logic [MAG_W-1:0]   spec_rd_data,
   input  logic [2:0]         sw_n,
   output logic               vga_hs_n,
   output logic               vga_vs_n,
   output logic [COLOR_W-1:0] vga_r,
   output logic [COLOR_W-1:0] vga_g,
   output logic [COLOR_W-1:0] vga_b
);

   localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
   localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
   localparam int H_W     = $clog2(H_TOTAL);
   localparam int V_W     = $clog2(V_TOTAL);
   localparam int HGT_W   = $clog2(V_ACTIVE + 1);
   localparam int NBINS   = NUM_BARS * BINS_PER_BAR;

   if (H_ACTIVE % NUM_BARS != 0) begin : g_bad_width
      $error("H_ACTIVE must be a multiple of NUM_BARS");
   end
   if (BINS_PER_BAR < 2 || (BINS_PER_BAR & (BINS_PER_BAR - 1)) != 0) begin : g_bad_group
      $error("BINS_PER_BAR must be a power of two, at least 2");
   end
   if (NUM_BARS < 2) begin : g_bad_bars
      $error("NUM_BARS must be at least 2");
   end
   if (NBINS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the bins that are read");
   end
   if (V_TOTAL - V_ACTIVE < 2) begin : g_bad_blank
      $error("vertical blanking must last at least two lines");
   end

   logic [H_W-1:0]                        h;
   logic [V_W-1:0]                        v;
   logic                                  active;
   logic                                  hs_n;
   logic                                  vs_n;
   logic                                  upd_ok;
   logic [NUM_BARS-1:0][HGT_W-1:0]        heights;
   logic [SB_CHANNELS-1:0][COLOR_W-1:0]   rgb;

   sb_loader #(
      .MAG_W(MAG_W), .ADDR_W(ADDR_W), .NUM_BARS(NUM_BARS),
      .BINS_PER_BAR(BINS_PER_BAR), .SHIFT(SHIFT), .V_ACTIVE(V_ACTIVE),
      .HGT_W(HGT_W)
   ) u_loader (
      .clk(load_clk), .rst_n(rst_n), .xform_done(xform_done),
      .upd_ok_pix(upd_ok), .rd_en(spec_rd_en), .rd_addr(spec_rd_addr),
      .rd_data(spec_rd_data), .heights_o(heights)
   );

   sb_timing #(
      .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
      .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
      .H_W(H_W), .V_W(V_W)
   ) u_timing (
      .clk(pix_clk), .rst_n(rst_n), .h_o(h), .v_o(v), .active_o(active),
      .hs_n_o(hs_n), .vs_n_o(vs_n), .upd_ok_o(upd_ok)
   );

   sb_raster #(
      .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .NUM_BARS(NUM_BARS),
      .HGT_W(HGT_W), .COLOR_W(COLOR_W), .H_W(H_W), .V_W(V_W)
   ) u_raster (
      .clk(pix_clk), .rst_n(rst_n), .h_i(h), .v_i(v), .active_i(active),
      .hs_n_i(hs_n), .vs_n_i(vs_n), .heights_i(heights), .sw_n(sw_n),
      .hs_n_o(vga_hs_n), .vs_n_o(vga_vs_n), .rgb_o(rgb)
   );

   assign vga_r = rgb[0];
   assign vga_g = rgb[1];
   assign vga_b = rgb[2];

endmodule

// File: tb/tb_spectrum_bars.sv
module tb_spectrum_bars;

   localparam int HA = 64, HF = 2, HS = 4, HB = 2;
   localparam int VA = 32, VF = 1, VS = 2, VB = 1;
   localparam int HT = HA + HF + HS + HB;
   localparam int VT = VA + VF + VS + VB;
   localparam int NB = 16;
   localparam int BPX = HA / NB;
   localparam int SH = 4;
   localparam int CW = 4;

   typedef logic [NB-1:0][7:0] hset_t;

   logic          load_clk = 1'b0;
   logic          pix_clk  = 1'b0;
   logic          rst_n    = 1'b1;
   logic          xform_done = 1'b0;
   logic          spec_rd_en;
   logic [7:0]    spec_rd_addr;
   logic [15:0]   spec_rd_data = '0;
   logic [2:0]    sw_n = 3'b111;
   logic          vga_hs_n, vga_vs_n;
   logic [CW-1:0] vga_r, vga_g, vga_b;

   logic [15:0]   mem [256];
   int            checks = 0;
   int            errors = 0;
   int            pos = -1;
   int            cur_h, cur_v;
   string         phase = "R10";
   hset_t         exp_q[$];
   hset_t         cur_set = '0;
   bit            done_flag = 0;

   spectrum_bars #(
      .NUM_BARS(NB), .SHIFT(SH), .COLOR_W(CW),
      .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
      .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
   ) dut (
      .load_clk(load_clk), .pix_clk(pix_clk), .rst_n(rst_n),
      .xform_done(xform_done), .spec_rd_en(spec_rd_en),
      .spec_rd_addr(spec_rd_addr), .spec_rd_data(spec_rd_data), .sw_n(sw_n),
      .vga_hs_n(vga_hs_n), .vga_vs_n(vga_vs_n),
      .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b)
   );

   always #5  load_clk = ~load_clk;
   always #10 pix_clk  = ~pix_clk;

   // Memory model: one-cycle synchronous read.
   always @(posedge load_clk) if (spec_rd_en) spec_rd_data <= mem[spec_rd_addr];

   // Raster position shown at the outputs after each pixel edge.
   always @(posedge pix_clk) if (rst_n) pos <= pos + 1;
   always_comb begin
      cur_h = (pos < 0) ? 0 : pos % HT;
      cur_v = (pos < 0) ? 0 : (pos / HT) % VT;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at h=%0d v=%0d: actual %0h expected %0h", tag, cur_h, cur_v, act, exp);
      end
   endtask

   function automatic int exp_height(input int a, input int b);
      int r = (a + b) >> SH;
      return (r > VA) ? VA : r;
   endfunction

   // Monitor: pops a queued height set at the start of vertical blanking, then compares every pixel.
   always @(negedge pix_clk) begin
      if (pos >= 0 && !done_flag) begin
         bit act, lit, ehs, evs;
         logic [3*CW-1:0] exp_rgb;
         if (cur_v == VA && cur_h == 0 && exp_q.size() > 0) cur_set = exp_q.pop_front();
         ehs = !(cur_h >= HA + HF && cur_h < HA + HF + HS);
         evs = !(cur_v >= VA + VF && cur_v < VA + VF + VS);
         act = (cur_h < HA) && (cur_v < VA);
         lit = act && (cur_v >= VA - int'(cur_set[cur_h / BPX]));
         exp_rgb = {(lit && sw_n[2]) ? {CW{1'b1}} : {CW{1'b0}},
                    (lit && sw_n[1]) ? {CW{1'b1}} : {CW{1'b0}},
                    (lit && sw_n[0]) ? {CW{1'b1}} : {CW{1'b0}}};
         check(vga_hs_n == ehs, "R6 hsync", int'(vga_hs_n), int'(ehs));
         check(vga_vs_n == evs, "R7 vsync", int'(vga_vs_n), int'(evs));
         check({vga_b, vga_g, vga_r} == exp_rgb,
               act ? {phase, " R3 pixel"} : "R8 blank colour",
               int'({vga_b, vga_g, vga_r}), int'(exp_rgb));
      end
   end

   task automatic wait_pos(input int v, input int h);
      do @(negedge pix_clk); while (!(cur_v == v && cur_h == h));
   endtask

   task automatic pulse_done();
      @(negedge load_clk) xform_done = 1'b1;
      @(negedge load_clk) xform_done = 1'b0;
   endtask

   // Driver: fills the memory, queues the heights the requirements predict, triggers a load.
   task automatic load_pair_set(input int a[NB], input int b[NB], input string tag);
      hset_t s;
      wait_pos(2, 0);
      phase = tag;
      for (int i = 0; i < NB; i++) begin
         mem[2*i]   = 16'(a[i]);
         mem[2*i+1] = 16'(b[i]);
         s[i] = 8'(exp_height(a[i], b[i]));
      end
      exp_q.push_back(s);
      pulse_done();
   endtask

   initial begin
      int a[NB];
      int b[NB];
      for (int i = 0; i < 256; i++) mem[i] = (i < 2*NB) ? 16'h0 : 16'hFFFF;
      #1 rst_n = 1'b0;
      #49;
      // R10: reset state at the ports
      check(vga_hs_n == 1'b1, "R10 reset hsync", int'(vga_hs_n), 1);
      check(vga_vs_n == 1'b1, "R10 reset vsync", int'(vga_vs_n), 1);
      check({vga_r, vga_g, vga_b} == '0, "R10 reset colour", int'({vga_r, vga_g, vga_b}), 0);
      #52 rst_n = 1'b1;

      // R10: first frame dark with zero heights
      wait_pos(VA + 1, 0);

      // R1, R2: ramp of bars, high bins saturated to show they are ignored
      for (int i = 0; i < NB; i++) begin a[i] = i * 16; b[i] = i * 16; end
      load_pair_set(a, b, "R1");
      wait_pos(VA + 1, 0);
      wait_pos(VA + 1, 0);

      // R5 then R2: mid-frame request, clamp and rounding corners
      a[0] = 0;     b[0] = 0;
      a[1] = 256;   b[1] = 256;
      a[2] = 65535; b[2] = 65535;
      a[3] = 15;    b[3] = 1;
      a[4] = 16;    b[4] = 15;
      for (int i = 5; i < NB; i++) begin a[i] = (i * 97) % 300; b[i] = i * 11; end
      load_pair_set(a, b, "R5");
      wait_pos(VA + 1, 0);
      phase = "R2";
      wait_pos(VA + 1, 0);

      // R4: memory changes without a done pulse, picture must stay
      wait_pos(2, 0);
      phase = "R4";
      for (int i = 0; i < 2*NB; i++) mem[i] = 16'd200;
      wait_pos(VA + 1, 0);
      wait_pos(VA + 1, 0);

      // R9: switch combinations applied during blanking
      phase = "R9";
      wait_pos(VA + 1, 0); sw_n = 3'b110;
      wait_pos(VA + 1, 0); sw_n = 3'b010;
      wait_pos(VA + 1, 0); sw_n = 3'b000;
      wait_pos(VA + 1, 0); sw_n = 3'b101;
      wait_pos(VA + 1, 0); sw_n = 3'b111;
      wait_pos(VA + 1, 0);

      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge load_clk);
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule